// File: doc/BRIEF.md
# Core Selector with Read-Latency Alignment

This block sits between one system register bus and a set of peripheral cores. It splits each bus address into a core number and a register index, and raises chip select on the addressed core only. Write enable and write data go to every core. Each core receives a local address, and the width of that address depends on how many core slots the core occupies. A read returns the addressed core's 32-bit word and error flag on the bus.

The list of cores is fixed by parameters. Each core has a base slot, a slot span given as a power of two (1, 4 or 16 slots), and three flags: whether it reads through block memory, whether it drives an error line, and whether its reset is active-high. A block-memory core needs one extra clock to return data. When any attached core has that extra clock, every other core's data and error pass through one register, and the registered selection is delayed by the same clock. All cores then answer with one common latency. When no core uses block memory, nothing is added.

The default map has a plain core at slot 0x00, a plain core without an error line at 0x01, a four-slot block-memory core at 0x04 to 0x07, and a sixteen-slot sub-addressed core at 0x10 to 0x1F.

Top module: `csel_top`

## Requirements
- R1: The 16-bit bus address is split into core number = addr[15:8] and register index = addr[7:0]. There is no level above the core number.
- R2: `core_cs` is one-hot on the core whose slot range holds the core number, and only while `sys_cs` is 1. Otherwise it is all zero. `core_we` equals `sys_we` and `core_wdata` equals `sys_wdata` for all cores.
- R3: A core spanning 2^k slots receives the 12-bit local address {core number[k-1:0], register index}, zero-extended. A single-slot core gets {4'h0, index}. The four-slot core gets {2'b00, cn[1:0], index} on every one of its four slots.
- R4: A read (`sys_cs`=1, `sys_we`=0) sampled at rising edge T returns its data and error after edge T+L-1. L is 2 when any core uses block memory and 1 otherwise. Back-to-back reads to different cores return in order, one per cycle. Between reads, the output keeps the last read's selection.
- R5: With alignment active, only the non-block-memory cores get one data/error register; block-memory cores feed the mux directly. With no block-memory core, every core feeds the mux with no register.
- R6: A core configured without an error line returns error 0, even if it drives 1. A core with an error line returns its own error value.
- R7: A read from an unmapped core number (default map: 0x02, 0x03, 0x08 to 0x0F, 0x20 to 0xFF) returns data 0 and error 1 with latency L.
- R8: `core_rst[i]` equals `sys_rst` for an active-high core and `~sys_rst` for an active-low core. The default has only core 1 active-high.
- R9: The sixteen-slot core receives all 12 address bits unchanged, including sub-block numbers 1 to 4, 7 to 9 and C to F, where it has no sub-block. The error for those comes from the core, and the selector does not filter it.
- R10: After reset, with no read issued, the selection points at core number 0 and the bus shows core 0's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous reset, active high |
| sys_cs | input | 1 | Bus chip select |
| sys_we | input | 1 | Bus write enable |
| sys_addr | input | 16 | Bus address {core number, register index} |
| sys_wdata | input | 32 | Bus write data |
| sys_rdata | output | 32 | Read data returned on the bus |
| sys_err | output | 1 | Error returned on the bus |
| core_cs | output | N_CORES | Per-core chip select |
| core_we | output | 1 | Write enable to all cores |
| core_addr | output | N_CORES*12 | Per-core local address, core i at bits [12i+11:12i] |
| core_wdata | output | 32 | Write data to all cores |
| core_rdata | input | N_CORES*32 | Per-core read data, core i at bits [32i+31:32i] |
| core_err | input | N_CORES | Per-core error |
| core_rst | output | N_CORES | Per-core reset with the core's own polarity |

## Verification
The bench runs the default map and a copy with no block-memory core side by side. It checks that both deliver every core's data on the cycle their latency predicts. A design that registered the wrong set of cores, or forgot to delay the selection, would show the neighbouring read's word in back-to-back bursts. Reads to the edges of the four-slot and sixteen-slot ranges, and to unmapped numbers just outside them, catch off-by-one slot decoding. Reads with index bit 7 set, on the core without an error line, catch error lines routed without regard to configuration. Gap sub-blocks catch a selector that truncates or filters the sub-addressed core's address.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int CN_W   = 8;            // core number width
  localparam int RI_W   = 8;            // register index width
  localparam int ADDR_W = CN_W + RI_W;  // bus address width
  localparam int DW     = 32;           // data width
  localparam int LA_W   = 12;           // per-core local address width
  localparam int LG_W   = 4;            // slot span log2 field width

  // True when core number cn falls in the 2^lg slots starting at base.
  function automatic logic slot_hit(logic [CN_W-1:0] cn, logic [CN_W-1:0] base,
                                    logic [LG_W-1:0] lg);
    return (cn >> lg) == (base >> lg);
  endfunction

  // Local address: the low lg core-number bits above the register index.
  function automatic logic [LA_W-1:0] local_addr(logic [CN_W-1:0] cn,
                                                 logic [RI_W-1:0] ri,
                                                 logic [LG_W-1:0] lg);
    logic [CN_W-1:0] mask;
    logic [CN_W-1:0] low;
    mask = CN_W'((32'd1 << lg) - 32'd1);
    low  = cn & mask;
    return LA_W'({low, ri});
  endfunction
endpackage

// File: rtl/csel_decode.sv
module csel_decode #(
  parameter int N_CORES = 4,
  parameter logic [N_CORES*csel_pkg::CN_W-1:0] CORE_BASE = '0,
  parameter logic [N_CORES*csel_pkg::LG_W-1:0] CORE_SPAN_LG = '0
) (
  input  logic                                   bus_cs,
  input  logic [csel_pkg::CN_W-1:0]              cn,
  input  logic [csel_pkg::RI_W-1:0]              ri,
  output logic [N_CORES-1:0]                     cs_vec,
  output logic [N_CORES*csel_pkg::LA_W-1:0]      la_vec
);
  import csel_pkg::*;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    localparam logic [CN_W-1:0] BASE = CORE_BASE[i*CN_W +: CN_W];
    localparam logic [LG_W-1:0] LG   = CORE_SPAN_LG[i*LG_W +: LG_W];
    assign cs_vec[i] = bus_cs & slot_hit(cn, BASE, LG);
    assign la_vec[i*LA_W +: LA_W] = local_addr(cn, ri, LG);
  end
endmodule

// File: rtl/csel_align.sv
module csel_align #(
  parameter int N_CORES = 4,
  parameter logic [N_CORES-1:0] CORE_BLKMEM = '0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N_CORES*csel_pkg::DW-1:0]   in_rdata,
  input  logic [N_CORES-1:0]                in_err,
  output logic [N_CORES*csel_pkg::DW-1:0]   out_rdata,
  output logic [N_CORES-1:0]                out_err
);
  import csel_pkg::*;
  localparam bit ALIGN_ON = |CORE_BLKMEM;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    if (ALIGN_ON && !CORE_BLKMEM[i]) begin : g_reg
      logic [DW-1:0] d_q;
      logic          e_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          d_q <= '0;
          e_q <= 1'b0;
        end else begin
          d_q <= in_rdata[i*DW +: DW];
          e_q <= in_err[i];
        end
      end
      assign out_rdata[i*DW +: DW] = d_q;
      assign out_err[i]            = e_q;
    end else begin : g_thru
      assign out_rdata[i*DW +: DW] = in_rdata[i*DW +: DW];
      assign out_err[i]            = in_err[i];
    end
  end
endmodule

// File: rtl/csel_readmux.sv
module csel_readmux #(
  parameter int N_CORES = 4,
  parameter logic [N_CORES*csel_pkg::CN_W-1:0] CORE_BASE = '0,
  parameter logic [N_CORES*csel_pkg::LG_W-1:0] CORE_SPAN_LG = '0
) (
  input  logic [csel_pkg::CN_W-1:0]         sel_cn,
  input  logic [N_CORES*csel_pkg::DW-1:0]   al_rdata,
  input  logic [N_CORES-1:0]                al_err,
  output logic [csel_pkg::DW-1:0]           rdata,
  output logic                              err,
  output logic                              miss
);
  import csel_pkg::*;

  always_comb begin
    rdata = '0;
    err   = 1'b1;
    miss  = 1'b1;
    for (int i = 0; i < N_CORES; i++) begin
      if (slot_hit(sel_cn, CORE_BASE[i*CN_W +: CN_W], CORE_SPAN_LG[i*LG_W +: LG_W])) begin
        rdata = al_rdata[i*DW +: DW];
        err   = al_err[i];
        miss  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/csel_top.sv
module csel_top #(
  parameter int N_CORES = 4,
  parameter logic [N_CORES*8-1:0] CORE_BASE     = 32'h10_04_01_00,
  parameter logic [N_CORES*4-1:0] CORE_SPAN_LG  = 16'h4200,
  parameter logic [N_CORES-1:0]   CORE_BLKMEM   = 4'b0100,
  parameter logic [N_CORES-1:0]   CORE_HAS_ERR  = 4'b1101,
  parameter logic [N_CORES-1:0]   CORE_RST_HIGH = 4'b0010
) (
  input  logic                     clk,
  input  logic                     sys_rst,
  input  logic                     sys_cs,
  input  logic                     sys_we,
  input  logic [15:0]              sys_addr,
  input  logic [31:0]              sys_wdata,
  output logic [31:0]              sys_rdata,
  output logic                     sys_err,
  output logic [N_CORES-1:0]       core_cs,
  output logic                     core_we,
  output logic [N_CORES*12-1:0]    core_addr,
  output logic [31:0]              core_wdata,
  input  logic [N_CORES*32-1:0]    core_rdata,
  input  logic [N_CORES-1:0]       core_err,
  output logic [N_CORES-1:0]       core_rst
);
  import csel_pkg::*;
  localparam bit ALIGN_ON = |CORE_BLKMEM;

  // Named internal events, visible to the bound checker.
  logic [CN_W-1:0]        cn;
  logic [RI_W-1:0]        ri;
  logic                   rd_req;
  logic [CN_W-1:0]        sel_q;
  logic [CN_W-1:0]        sel_out;
  logic                   out_miss;
  logic [N_CORES-1:0]     err_m;
  logic [N_CORES*DW-1:0]  al_rdata;
  logic [N_CORES-1:0]     al_err;

  assign cn     = sys_addr[ADDR_W-1 -: CN_W];
  assign ri     = sys_addr[RI_W-1:0];
  assign rd_req = sys_cs & ~sys_we;

  assign core_we    = sys_we;
  assign core_wdata = sys_wdata;
  assign core_rst   = ({N_CORES{sys_rst}} & CORE_RST_HIGH) |
                      ({N_CORES{~sys_rst}} & ~CORE_RST_HIGH);
  assign err_m      = core_err & CORE_HAS_ERR;

  csel_decode #(
    .N_CORES(N_CORES), .CORE_BASE(CORE_BASE), .CORE_SPAN_LG(CORE_SPAN_LG)
  ) u_dec (
    .bus_cs(sys_cs), .cn(cn), .ri(ri), .cs_vec(core_cs), .la_vec(core_addr)
  );

  // Selection capture: the core number of the latest read.
  always_ff @(posedge clk) begin
    if (sys_rst)      sel_q <= '0;
    else if (rd_req)  sel_q <= cn;
  end

  if (ALIGN_ON) begin : g_sel_dly
    logic [CN_W-1:0] sel_d;
    always_ff @(posedge clk) begin
      if (sys_rst) sel_d <= '0;
      else         sel_d <= sel_q;
    end
    assign sel_out = sel_d;
  end else begin : g_sel_thru
    assign sel_out = sel_q;
  end

  csel_align #(
    .N_CORES(N_CORES), .CORE_BLKMEM(CORE_BLKMEM)
  ) u_align (
    .clk(clk), .rst(sys_rst), .in_rdata(core_rdata), .in_err(err_m),
    .out_rdata(al_rdata), .out_err(al_err)
  );

  csel_readmux #(
    .N_CORES(N_CORES), .CORE_BASE(CORE_BASE), .CORE_SPAN_LG(CORE_SPAN_LG)
  ) u_mux (
    .sel_cn(sel_out), .al_rdata(al_rdata), .al_err(al_err),
    .rdata(sys_rdata), .err(sys_err), .miss(out_miss)
  );
endmodule

// File: rtl/csel_top_chk.sv
module csel_top_chk #(
  parameter int N_CORES = 4,
  parameter logic [N_CORES*8-1:0] CORE_BASE    = '0,
  parameter logic [N_CORES*4-1:0] CORE_SPAN_LG = '0,
  parameter logic [N_CORES-1:0]   CORE_BLKMEM  = '0,
  parameter logic [N_CORES-1:0]   CORE_HAS_ERR = '0
) (
  input logic               clk,
  input logic               sys_rst,
  input logic               sys_cs,
  input logic               sys_we,
  input logic [7:0]         cn_in,
  input logic [31:0]        sys_rdata,
  input logic               sys_err,
  input logic [N_CORES-1:0] core_cs,
  input logic [7:0]         sel_q,
  input logic [7:0]         sel_out,
  input logic               out_miss
);
  import csel_pkg::*;
  localparam bit ALIGN_ON = |CORE_BLKMEM;

  logic armed;
  always_ff @(posedge clk) begin
    if (sys_rst) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic noerr_sel;
  always_comb begin
    noerr_sel = 1'b0;
    for (int i = 0; i < N_CORES; i++)
      if (!CORE_HAS_ERR[i] && slot_hit(sel_out, CORE_BASE[i*8 +: 8], CORE_SPAN_LG[i*4 +: 4]))
        noerr_sel = 1'b1;
  end

  a_r2_cs_onehot: assert property (@(posedge clk) disable iff (sys_rst)
    $onehot0(core_cs));
  a_r2_cs_gated: assert property (@(posedge clk) disable iff (sys_rst)
    !sys_cs |-> core_cs == '0);
  a_r4_sel_capture: assert property (@(posedge clk) disable iff (sys_rst)
    (sys_cs && !sys_we) |=> sel_q == $past(cn_in));
  a_r4_sel_hold: assert property (@(posedge clk) disable iff (sys_rst)
    !(sys_cs && !sys_we) |=> $stable(sel_q));
  a_r5_sel_align: assert property (@(posedge clk) disable iff (sys_rst)
    armed |-> sel_out == (ALIGN_ON ? $past(sel_q) : sel_q));
  a_r6_no_err_line: assert property (@(posedge clk) disable iff (sys_rst)
    noerr_sel |-> !sys_err);
  a_r7_unmapped: assert property (@(posedge clk) disable iff (sys_rst)
    out_miss |-> (sys_rdata == '0 && sys_err));
endmodule

bind csel_top csel_top_chk #(
  .N_CORES(N_CORES), .CORE_BASE(CORE_BASE), .CORE_SPAN_LG(CORE_SPAN_LG),
  .CORE_BLKMEM(CORE_BLKMEM), .CORE_HAS_ERR(CORE_HAS_ERR)
) u_chk (
  .clk(clk), .sys_rst(sys_rst), .sys_cs(sys_cs), .sys_we(sys_we),
  .cn_in(sys_addr[15:8]), .sys_rdata(sys_rdata), .sys_err(sys_err),
  .core_cs(core_cs), .sel_q(sel_q), .sel_out(sel_out), .out_miss(out_miss)
);

// File: tb/csel_top_tb_top.sv
module csel_stub #(
  parameter int ID = 0,
  parameter int STAGES = 1,
  parameter bit GAPPED = 1'b0,
  parameter bit RST_HIGH = 1'b0
) (
  input  logic        clk,
  input  logic        rst_in,
  input  logic        cs,
  input  logic        we,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        err
);
  logic rst;
  assign rst = RST_HIGH ? rst_in : !rst_in;
  logic [31:0] mem [16];
  logic [31:0] d1;
  logic        e1;
  logic        gap;
  always_comb begin
    case (addr[11:8])
      4'h0, 4'h5, 4'h6, 4'hA, 4'hB: gap = 1'b0;
      default:                       gap = 1'b1;
    endcase
  end
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 16; k++) mem[k] <= '0;
      d1 <= '0;
      e1 <= 1'b0;
    end else if (cs && we) begin
      mem[addr[3:0]] <= wdata;
    end else if (cs) begin
      d1 <= mem[addr[3:0]] ^ {ID[7:0], 12'h000, addr};
      e1 <= GAPPED ? gap : addr[7];
    end
  end
  if (STAGES == 2) begin : g_two
    logic [31:0] d2;
    logic        e2;
    always_ff @(posedge clk) begin
      if (rst) begin d2 <= '0; e2 <= 1'b0; end
      else     begin d2 <= d1; e2 <= e1; end
    end
    assign rdata = d2;
    assign err   = e2;
  end else begin : g_one
    assign rdata = d1;
    assign err   = e1;
  end
endmodule

module csel_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [N-1:0] BLK_A = 4'b0100;
  localparam logic [N-1:0] BLK_B = 4'b0000;
  localparam logic [N-1:0] RSTH  = 4'b0010;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        sys_rst, sys_cs, sys_we;
  logic [15:0] sys_addr;
  logic [31:0] sys_wdata;

  logic [31:0]     rd_i, rd_n, wd_i, wd_n;
  logic            er_i, er_n, we_i, we_n;
  logic [N-1:0]    cs_i, cs_n, rst_i, rst_n;
  logic [N*12-1:0] la_i, la_n;
  logic [N*32-1:0] crd_i, crd_n;
  logic [N-1:0]    cer_i, cer_n;

  csel_top dut_i (
    .clk(clk), .sys_rst(sys_rst), .sys_cs(sys_cs), .sys_we(sys_we),
    .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_rdata(rd_i), .sys_err(er_i),
    .core_cs(cs_i), .core_we(we_i), .core_addr(la_i), .core_wdata(wd_i),
    .core_rdata(crd_i), .core_err(cer_i), .core_rst(rst_i));

  csel_top #(.CORE_BLKMEM(BLK_B)) dut_nb (
    .clk(clk), .sys_rst(sys_rst), .sys_cs(sys_cs), .sys_we(sys_we),
    .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_rdata(rd_n), .sys_err(er_n),
    .core_cs(cs_n), .core_we(we_n), .core_addr(la_n), .core_wdata(wd_n),
    .core_rdata(crd_n), .core_err(cer_n), .core_rst(rst_n));

  for (genvar i = 0; i < N; i++) begin : g_stub
    csel_stub #(.ID(i), .STAGES(BLK_A[i] ? 2 : 1), .GAPPED(i == 3), .RST_HIGH(RSTH[i])) u_a (
      .clk(clk), .rst_in(rst_i[i]), .cs(cs_i[i]), .we(we_i), .addr(la_i[i*12 +: 12]),
      .wdata(wd_i), .rdata(crd_i[i*32 +: 32]), .err(cer_i[i]));
    csel_stub #(.ID(i), .STAGES(BLK_B[i] ? 2 : 1), .GAPPED(i == 3), .RST_HIGH(RSTH[i])) u_b (
      .clk(clk), .rst_in(rst_n[i]), .cs(cs_n[i]), .we(we_n), .addr(la_n[i*12 +: 12]),
      .wdata(wd_n), .rdata(crd_n[i*32 +: 32]), .err(cer_n[i]));
  end

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [31:0] shadow [N][16];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench restatement of the default core map.
  function automatic int core_of(logic [7:0] cn);
    if (cn == 8'h00) return 0;
    if (cn == 8'h01) return 1;
    if (cn >= 8'h04 && cn <= 8'h07) return 2;
    if (cn >= 8'h10 && cn <= 8'h1F) return 3;
    return -1;
  endfunction

  function automatic logic [11:0] lad(int c, logic [7:0] cn, logic [7:0] ri);
    if (c == 2) return {2'b00, cn[1:0], ri};
    if (c == 3) return {cn[3:0], ri};
    return {4'h0, ri};
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] cn, logic [7:0] ri);
    int c = core_of(cn);
    if (c < 0) return 32'h0;
    return shadow[c][ri[3:0]] ^ {8'(c), 12'h000, lad(c, cn, ri)};
  endfunction

  function automatic logic exp_er(logic [7:0] cn, logic [7:0] ri);
    int c = core_of(cn);
    if (c < 0) return 1'b1;
    if (c == 1) return 1'b0;
    if (c == 3) return !(cn[3:0] inside {4'h0, 4'h5, 4'h6, 4'hA, 4'hB});
    return ri[7];
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Checks the request-side outputs of both instances (R1, R2, R3, R9).
  task automatic chk_req(logic [7:0] cn, logic [7:0] ri, logic we, logic [31:0] wd);
    int c = core_of(cn);
    logic [N-1:0] ecs = '0;
    if (c >= 0) ecs[c] = 1'b1;
    chk("R2 core_cs", 32'(cs_i), 32'(ecs));
    chk("R2 core_cs nb", 32'(cs_n), 32'(ecs));
    chk("R2 core_we", 32'(we_i), 32'(we));
    chk("R2 core_wdata", wd_i, wd);
    if (c >= 0) begin
      chk(c == 3 ? "R9 full 12-bit address" : "R1 R3 local address",
          32'(la_i[c*12 +: 12]), 32'(lad(c, cn, ri)));
      chk("R3 local address nb", 32'(la_n[c*12 +: 12]), 32'(lad(c, cn, ri)));
    end
  endtask

  task automatic do_op(logic we, logic [7:0] cn, logic [7:0] ri, logic [31:0] wd);
    logic [31:0] er_d;
    logic        er_e;
    int c = core_of(cn);
    @(negedge clk);
    sys_cs = 1'b1; sys_we = we; sys_addr = {cn, ri}; sys_wdata = wd;
    #1;
    chk_req(cn, ri, we, wd);
    er_d = exp_rd(cn, ri);
    er_e = exp_er(cn, ri);
    @(posedge clk);
    if (we && c >= 0) shadow[c][ri[3:0]] = wd;
    @(negedge clk);
    sys_cs = 1'b0;
    if (!we) begin
      chk("R4 R5 data no-blk L=1", rd_n, er_d);
      chk("R6 R7 err no-blk L=1", 32'(er_n), 32'(er_e));
    end
    @(negedge clk);
    if (!we) begin
      chk("R4 R5 data aligned L=2", rd_i, er_d);
      chk("R6 R7 R9 err aligned L=2", 32'(er_i), 32'(er_e));
    end
  endtask

  initial begin : watchdog
    for (int k = 0; k < 150000; k++) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin : main
    logic [15:0] ba [6];
    logic [31:0] bd [6];
    logic        be [6];
    void'($urandom(32'd20250611));
    for (int c = 0; c < N; c++) for (int k = 0; k < 16; k++) shadow[c][k] = '0;
    sys_rst = 1'b1; sys_cs = 1'b0; sys_we = 1'b0; sys_addr = '0; sys_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 core_rst in reset", 32'(rst_i), 32'(4'b0010));
    sys_rst = 1'b0;
    @(negedge clk);
    chk("R8 core_rst out of reset", 32'(rst_i), 32'(4'b1101));
    chk("R10 reset data", rd_i, 32'h0);
    chk("R10 reset err", 32'(er_i), 32'h0);
    chk("R2 idle core_cs", 32'(cs_i), 32'h0);

    // Directed corners.
    do_op(1'b1, 8'h00, 8'h03, 32'hA5A5_0001);
    do_op(1'b0, 8'h00, 8'h03, '0);
    do_op(1'b0, 8'h01, 8'h80, '0);          // R6: core drives err, no line
    do_op(1'b0, 8'h00, 8'h81, '0);          // R6: own err line
    do_op(1'b1, 8'h07, 8'h05, 32'h1234_5678);
    do_op(1'b0, 8'h04, 8'h05, '0);          // R3 four-slot range edges
    do_op(1'b0, 8'h07, 8'h85, '0);
    do_op(1'b0, 8'h03, 8'h00, '0);          // R7 just below
    do_op(1'b0, 8'h08, 8'h00, '0);          // R7 just above
    do_op(1'b0, 8'h10, 8'h01, '0);          // R9 sub-blocks
    do_op(1'b0, 8'h12, 8'h01, '0);
    do_op(1'b0, 8'h1B, 8'h01, '0);
    do_op(1'b0, 8'h1F, 8'h01, '0);
    do_op(1'b0, 8'h20, 8'h01, '0);
    do_op(1'b0, 8'hFF, 8'hFF, '0);

    // R4 back-to-back burst across cores with different latencies.
    ba[0] = 16'h0003; ba[1] = 16'h0405; ba[2] = 16'h0100;
    ba[3] = 16'h1507; ba[4] = 16'h0900; ba[5] = 16'h0681;
    for (int k = 0; k < 6; k++) begin
      bd[k] = exp_rd(ba[k][15:8], ba[k][7:0]);
      be[k] = exp_er(ba[k][15:8], ba[k][7:0]);
    end
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (c >= 1 && c - 1 < 6) begin
        chk("R4 burst data no-blk", rd_n, bd[c-1]);
        chk("R4 burst err no-blk", 32'(er_n), 32'(be[c-1]));
      end
      if (c >= 2) begin
        chk("R4 R5 burst data aligned", rd_i, bd[c-2]);
        chk("R4 R5 burst err aligned", 32'(er_i), 32'(be[c-2]));
      end
      if (c < 6) begin sys_cs = 1'b1; sys_we = 1'b0; sys_addr = ba[c]; end
      else sys_cs = 1'b0;
    end

    // Constrained random traffic.
    for (int n = 0; n < 400; n++) begin
      logic [7:0] cn = 8'($urandom % 40);
      logic [7:0] ri = 8'($urandom);
      logic we = ($urandom % 3) == 0;
      do_op(we, cn, ri, $urandom);
    end
    finish_up();
  end
endmodule